// File: doc/BRIEF.md
# Delta-Sigma ADC Serial Read Controller

This block is the host side of a three-wire link to a delta-sigma converter: it drives the chip-select and serial-clock lines and listens on the converter's serial data output. A one-cycle `start` request begins a transaction. When polling is enabled, the controller first asks the converter whether its conversion has finished. It holds select low for half a serial-clock period and reads the data line. A high level means the converter is still busy. The controller then releases select, waits a programmable number of system cycles and asks again. A low level means the converter is asleep with a result ready. When polling is off, the system decides readiness from its own timing and the read starts at once.

A read shifts in a 16-bit word, most significant bit first. Each bit is sampled on a rising serial-clock edge, half a period after the falling edge that launched it. Once the word is in, the controller starts the next conversion in one of two ways. It can raise select, or it can send one extra clocking step with select still low: a 17th pulse when the clock idles high, or the 16th falling edge when it idles low. It then raises select. The idle clock level, the start method and polling are sampled at `start` and held for the whole transaction. The serial clock runs at the system clock divided by `2*HALF_DIV`. The word appears on a parallel output with a one-cycle valid strobe.

Top module: `adc_serial_reader`

## Requirements
- R1: During and right after reset, `adc_cs_n` is 1, `busy` is 0, `result_valid` is 0 and `adc_sck` equals `cpol`.
- R2: While `busy` is 0, `adc_sck` follows `cpol` (1 = clock idles high, 0 = idles low) one cycle later, and `adc_cs_n` stays 1.
- R3: In a read, `adc_sck` first changes `HALF_DIV` cycles after `adc_cs_n` falls and then changes every `HALF_DIV` cycles. `adc_sdo` is sampled on each of the first 16 rising edges, the first sample becoming bit 15 of `result`.
- R4: With `trig_by_clock` = 0, select rises `HALF_DIV` cycles after the 16th rising edge. At that point there have been 16 rising and 16 falling edges for `cpol` = 1, and 16 rising and 15 falling edges for `cpol` = 0. For `cpol` = 0 the clock returns low `HALF_DIV` cycles after select rises.
- R5: With `trig_by_clock` = 1 and `cpol` = 1, 17 complete clock pulses (17 falling and 17 rising edges) occur with select low before select rises.
- R6: With `trig_by_clock` = 1 and `cpol` = 0, 16 rising and 16 falling edges occur with select low, and select rises with the clock low.
- R7: Each read raises `result_valid` for exactly one cycle while `busy` is 1, with `result` holding the word sampled in that read.
- R8: `busy` is 1 from the cycle after an accepted `start` until select is high and the clock is back at its idle level. A `start` while busy is ignored.
- R9: With `poll_en` = 1, each status probe holds select low for `HALF_DIV` cycles and samples `adc_sdo` at its end. A high sample releases select for `POLL_GAP` cycles and then probes again.
- R10: A low probe sample releases select for `HALF_DIV` cycles, after which the read frame of R3 begins.
- R11: With `poll_en` = 0, select falls in the cycle after `start` is accepted.
- R12: `cpol`, `trig_by_clock` and `poll_en` are captured at an accepted `start`. Changing them during the transaction does not alter its edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transaction (taken when idle) |
| poll_en | input | 1 | 1 = probe conversion status before reading |
| trig_by_clock | input | 1 | 1 = start next conversion with an extra clocking step, 0 = by select rising |
| cpol | input | 1 | Serial clock idle level |
| adc_sdo | input | 1 | Serial data / status from the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sck | output | 1 | Serial clock |
| result | output | DATA_W | Last word read, MSB received first |
| result_valid | output | 1 | One-cycle strobe for a new `result` |
| busy | output | 1 | Transaction in progress |

## Verification
The sequencer state shows up directly as edge counts on `adc_sck` between a fall and a rise of `adc_cs_n`. A wrong tick index or a bad mode latch yields 15, 17 or 18 rising edges, or select rising at the wrong clock level. This is visible by the end of the affected frame, within about 35 half periods. A bit-order or sample-edge error corrupts `result` at the first strobe. A poll-timer fault changes the measured select-high gap already after the first busy probe.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and the frame step table of the serial reader.
// Assumes ticks are counted from 1 inside a read frame.
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_BACKOFF,
        ST_GAP,
        ST_FRAME
    } rd_state_t;

    typedef struct packed {
        logic toggle;   // flip the serial clock at this tick
        logic cs_up;    // release chip select at this tick
        logic last;     // final tick of the frame
    } step_t;

    // Action for tick number k (1-based) of a frame of nbits data bits.
    function automatic step_t frame_step(input int unsigned k,
                                         input logic idle_hi,
                                         input logic by_clock,
                                         input int unsigned nbits);
        step_t       s;
        int unsigned ntog;
        s = '0;
        if (!idle_hi && !by_clock) begin
            // stop after the last rising edge, park the clock after select rises
            s.toggle = (k <= 2 * nbits - 1) || (k == 2 * nbits + 1);
            s.cs_up  = (k == 2 * nbits);
            s.last   = (k == 2 * nbits + 1);
        end else begin
            ntog     = 2 * nbits + ((idle_hi && by_clock) ? 2 : 0);
            s.toggle = (k <= ntog);
            s.cs_up  = (k == ntog + 1);
            s.last   = (k == ntog + 1);
        end
        return s;
    endfunction

endpackage

// File: rtl/adc_rd_tick.sv
`timescale 1ns/1ps
// Half-period timer: pulses `tick` once every HALF_DIV cycles while `run`
// is high, and restarts from zero whenever `run` drops.
module adc_rd_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == TOP);

    // Count system cycles within one half period of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || cnt_q == TOP) cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
    end

    // R3: half-period phase never passes its limit
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

    // R3: the phase is back at zero right after a tick
    p_phase_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/adc_rd_shreg.sv
`timescale 1ns/1ps
// Result shifter: takes one data bit per `take`, MSB first, up to W bits,
// then strobes `done` for one cycle. `clear` rearms it for a new read.
module adc_rd_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         take,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         done
);
    localparam int NW = $clog2(W + 1);
    localparam logic [NW-1:0] FULL = NW'(W);

    logic [NW-1:0] n_q;
    logic [W-1:0]  sh_q;
    logic          done_q;

    assign word = sh_q;
    assign done = done_q;

    // Shift in sampled bits and count them until the word is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= '0;
            sh_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clear) begin
                n_q <= '0;
            end else if (take && n_q != FULL) begin
                sh_q   <= {sh_q[W-2:0], din};
                n_q    <= n_q + 1'b1;
                done_q <= (n_q == FULL - 1'b1);
            end
        end
    end

    // R7: the completion strobe lasts a single cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: never more than W bits are taken in a read
    p_bits_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        n_q <= FULL);
endmodule

// File: rtl/adc_serial_reader.sv
`timescale 1ns/1ps
// Host-side read controller for a delta-sigma converter on a three-wire link.
// Optionally probes conversion status, reads a DATA_W-bit word MSB first on
// rising clock edges, then starts the next conversion by select or by clock.
// Assumes the converter changes its data on falling clock edges.
module adc_serial_reader #(
    parameter int DATA_W   = 16,
    parameter int HALF_DIV = 4,
    parameter int POLL_GAP = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              poll_en,
    input  logic              trig_by_clock,
    input  logic              cpol,
    input  logic              adc_sdo,
    output logic              adc_cs_n,
    output logic              adc_sck,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              busy
);
    import adc_rd_pkg::*;

    localparam int KW = $clog2(2 * DATA_W + 4);
    localparam int WW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
    localparam logic [WW-1:0] WAIT_TOP = WW'(POLL_GAP - 1);

    rd_state_t     state_q;
    logic          cs_q, sck_q;
    logic          cpol_q, trig_q, poll_q;
    logic [KW-1:0] k_q;
    logic [WW-1:0] wait_q;
    logic          tick, run, take, accept;
    step_t         step;

    assign run    = (state_q == ST_PROBE) || (state_q == ST_GAP) || (state_q == ST_FRAME);
    assign step   = frame_step(32'(k_q) + 32'd1, cpol_q, trig_q, DATA_W);
    assign take   = (state_q == ST_FRAME) && tick && step.toggle && !sck_q;
    assign accept = (state_q == ST_IDLE) && start;

    assign adc_cs_n = cs_q;
    assign adc_sck  = sck_q;
    assign busy     = (state_q != ST_IDLE);

    adc_rd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    adc_rd_shreg #(.W(DATA_W)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .take  (take),
        .din   (adc_sdo),
        .word  (result),
        .done  (result_valid)
    );

    // Transaction sequencer: probing, back-off, gap and the clocked frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_q    <= 1'b1;
            sck_q   <= cpol;
            cpol_q  <= 1'b0;
            trig_q  <= 1'b0;
            poll_q  <= 1'b0;
            k_q     <= '0;
            wait_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sck_q <= cpol;
                    if (start) begin
                        cpol_q  <= cpol;
                        trig_q  <= trig_by_clock;
                        poll_q  <= poll_en;
                        cs_q    <= 1'b0;
                        k_q     <= '0;
                        state_q <= poll_en ? ST_PROBE : ST_FRAME;
                    end
                end
                ST_PROBE: begin
                    if (tick) begin
                        cs_q <= 1'b1;
                        if (adc_sdo) begin
                            wait_q  <= '0;
                            state_q <= ST_BACKOFF;
                        end else begin
                            state_q <= ST_GAP;
                        end
                    end
                end
                ST_BACKOFF: begin
                    if (wait_q == WAIT_TOP) begin
                        cs_q    <= 1'b0;
                        state_q <= ST_PROBE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        cs_q    <= 1'b0;
                        k_q     <= '0;
                        state_q <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (tick) begin
                        k_q <= k_q + 1'b1;
                        if (step.toggle) sck_q <= ~sck_q;
                        if (step.cs_up)  cs_q  <= 1'b1;
                        if (step.last)   state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: select is released whenever no transaction is running
    p_free_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> adc_cs_n);

    // R8: a transaction ends with the clock parked at its captured idle level
    p_end_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (adc_sck == cpol_q));

    // R9: during back-off the link is quiet
    p_backoff_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF) |-> (adc_cs_n && adc_sck == cpol_q));

    // R7: the result strobe only occurs inside a transaction
    p_valid_in_txn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> busy);

    // R12: captured modes stay fixed while busy
    p_modes_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cpol_q) && $stable(trig_q) && $stable(poll_q)));
endmodule

// File: tb/test_adc_serial_reader.sv
`timescale 1ns/1ps
// Directed bench with a behavioural converter model on the serial link.
module test_adc_serial_reader;
    localparam int W    = 16;
    localparam int HALF = 4;
    localparam int GAP  = 20;
    localparam int CONV = 100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         poll_en = 1'b0;
    logic         trig_by_clock = 1'b0;
    logic         cpol = 1'b1;
    logic         adc_sdo;
    logic         cs_n, sck;
    logic [W-1:0] result;
    logic         result_valid, busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_serial_reader #(.DATA_W(W), .HALF_DIV(HALF), .POLL_GAP(GAP)) i_adc_serial_reader (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .poll_en       (poll_en),
        .trig_by_clock (trig_by_clock),
        .cpol          (cpol),
        .adc_sdo       (adc_sdo),
        .adc_cs_n      (cs_n),
        .adc_sck       (sck),
        .result        (result),
        .result_valid  (result_valid),
        .busy          (busy)
    );

    // ---------------- converter model ----------------
    int           cyc = 0;
    int           conv_until = 0;
    logic         m_busy = 1'b0;
    logic [W-1:0] m_word = 16'hA5C3;
    logic [W-1:0] m_next = 16'h0000;
    logic         m_by_clk = 1'b0;
    logic         m_cpol = 1'b1;
    int           m_bit = 15;
    int           m_rises = 0, m_falls = 0, m_convs = 0;
    int           n_sel = 0, n_valid = 0;
    int           t_fall = 0, t_rise = 0, t_last_up = 0;
    int           at_up_rises = 0, at_up_falls = 0, first_edge_dly = -1;
    logic         sck_at_up = 1'b0;
    logic [W-1:0] got_word = '0;
    int           lo_dur [0:63];
    int           hi_dur [0:63];
    int           n_lo = 0, n_hi = 0;

    assign adc_sdo = cs_n ? 1'b0 : (m_busy ? 1'b1 : m_word[m_bit]);

    task automatic begin_conv();
        conv_until = cyc + CONV;
        m_word     = m_next;
        m_convs++;
    endtask

    always @(negedge clk) begin
        cyc++;
        m_busy = (cyc < conv_until);
        if (result_valid) begin
            n_valid++;
            got_word = result;
        end
    end

    always @(negedge cs_n) begin
        m_rises = 0;
        m_falls = 0;
        m_bit   = 15;
        first_edge_dly = -1;
        t_fall  = cyc;
        n_sel++;
        if (n_hi < 64) begin hi_dur[n_hi] = cyc - t_rise; n_hi++; end
    end

    always @(posedge sck) if (!cs_n) begin
        if (first_edge_dly < 0) first_edge_dly = cyc - t_fall;
        m_rises++;
        t_last_up = cyc;
    end

    always @(negedge sck) if (!cs_n) begin
        if (first_edge_dly < 0) first_edge_dly = cyc - t_fall;
        m_falls++;
        if (m_rises > 0 && m_bit > 0) m_bit--;
        if (m_by_clk && m_falls == (m_cpol ? 17 : 16)) begin_conv();
    end

    always @(posedge cs_n) begin
        at_up_rises = m_rises;
        at_up_falls = m_falls;
        sck_at_up   = sck;
        t_rise      = cyc;
        if (n_lo < 64) begin lo_dur[n_lo] = cyc - t_fall; n_lo++; end
        if (!m_by_clk && m_rises >= 16) begin_conv();
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (CONV + 20) @(negedge clk);
    endtask

    // One plain read in a chosen mode; returns captured edge data via globals.
    task automatic plain_read(input logic p, input logic byclk, input logic [W-1:0] nxt);
        @(negedge clk);
        cpol = p; trig_by_clock = byclk; poll_en = 1'b0;
        m_cpol = p; m_by_clk = byclk; m_next = nxt;
        repeat (3) @(negedge clk);
        pulse_start();
        wait_idle();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(result_valid == 1'b0, "R1 valid in reset", result_valid, 0);
        check(sck == cpol, "R1 sck idle in reset", sck, cpol);
        @(negedge clk) cpol = 1'b0;
        @(negedge clk) @(negedge clk);
        check(sck == 1'b0 && cs_n, "R2 idle sck follows cpol low", sck, 0);
        @(negedge clk) cpol = 1'b1;
        @(negedge clk) @(negedge clk);
        check(sck == 1'b1 && cs_n, "R2 idle sck follows cpol high", sck, 1);
    endtask

    task automatic t_sel_hi();
        logic [W-1:0] exp = m_word;
        int v0 = n_valid, c0 = m_convs;
        plain_read(1'b1, 1'b0, 16'hF00F);
        check(got_word == exp, "R3 word cpol1 select mode", got_word, exp);
        check(first_edge_dly == HALF, "R3 first edge delay", first_edge_dly, HALF);
        check(n_valid == v0 + 1, "R7 one strobe per read", n_valid - v0, 1);
        check(at_up_rises == 16 && at_up_falls == 16, "R4 edges before select rise cpol1",
              at_up_rises * 100 + at_up_falls, 1616);
        check(t_rise - t_last_up == HALF, "R4 select rise delay", t_rise - t_last_up, HALF);
        check(m_convs == c0 + 1, "R4 conversion started by select", m_convs - c0, 1);
        settle();
    endtask

    task automatic t_clk_hi();
        logic [W-1:0] exp = m_word;
        int c0 = m_convs;
        plain_read(1'b1, 1'b1, 16'h8001);
        check(got_word == exp, "R5 word cpol1 clock mode", got_word, exp);
        check(at_up_rises == 17 && at_up_falls == 17, "R5 seventeen pulses",
              at_up_rises * 100 + at_up_falls, 1717);
        check(m_convs == c0 + 1, "R5 conversion started by clock", m_convs - c0, 1);
        settle();
    endtask

    task automatic t_clk_lo();
        logic [W-1:0] exp = m_word;
        int c0 = m_convs;
        plain_read(1'b0, 1'b1, 16'h1234);
        check(got_word == exp, "R6 word cpol0 clock mode", got_word, exp);
        check(at_up_rises == 16 && at_up_falls == 16, "R6 sixteen falling edges",
              at_up_rises * 100 + at_up_falls, 1616);
        check(sck_at_up == 1'b0, "R6 clock low at select rise", sck_at_up, 0);
        check(m_convs == c0 + 1, "R6 conversion started by 16th fall", m_convs - c0, 1);
        settle();
    endtask

    task automatic t_sel_lo();
        logic [W-1:0] exp = m_word;
        plain_read(1'b0, 1'b0, 16'hFFFF);
        check(got_word == exp, "R3 word cpol0 select mode", got_word, exp);
        check(at_up_rises == 16 && at_up_falls == 15, "R4 edges before select rise cpol0",
              at_up_rises * 100 + at_up_falls, 1615);
        check(sck_at_up == 1'b1, "R4 clock high at select rise cpol0", sck_at_up, 1);
        check(sck == 1'b0, "R4 clock parked low after frame", sck, 0);
        settle();
    endtask

    task automatic t_immediate_and_busy();
        int s0;
        logic [W-1:0] exp = m_word;
        @(negedge clk);
        cpol = 1'b1; trig_by_clock = 1'b0; poll_en = 1'b0;
        m_cpol = 1'b1; m_by_clk = 1'b0; m_next = 16'h3A5C;
        repeat (2) @(negedge clk);
        s0 = n_sel;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(cs_n == 1'b0 && busy, "R11 select falls right after start", cs_n, 0);
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_idle();
        check(n_sel == s0 + 1, "R8 start while busy ignored", n_sel - s0, 1);
        repeat (5) @(negedge clk);
        check(!busy && cs_n, "R8 stays idle after ignored start", busy, 0);
        check(got_word == exp, "R8 word of single read", got_word, exp);
        settle();
    endtask

    task automatic t_latch();
        @(negedge clk);
        cpol = 1'b1; trig_by_clock = 1'b0; poll_en = 1'b0;
        m_cpol = 1'b1; m_by_clk = 1'b0; m_next = 16'h3A5C;
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (20) @(negedge clk);
        cpol = 1'b0; trig_by_clock = 1'b1; poll_en = 1'b1;
        wait_idle();
        check(at_up_rises == 16 && at_up_falls == 16, "R12 modes held mid-frame",
              at_up_rises * 100 + at_up_falls, 1616);
        @(negedge clk);
        check(sck == 1'b0, "R2 idle level takes new cpol after frame", sck, 0);
        cpol = 1'b1; trig_by_clock = 1'b0; poll_en = 1'b0;
        settle();
    endtask

    task automatic t_poll();
        int probes;
        logic [W-1:0] exp;
        @(negedge clk);
        cpol = 1'b1; trig_by_clock = 1'b0; poll_en = 1'b1;
        m_cpol = 1'b1; m_by_clk = 1'b0; m_next = 16'h0F0F;
        conv_until = cyc + 200;
        repeat (3) @(negedge clk);
        exp = m_word;            // word made ready is 0x3A5C, bit 15 low
        n_lo = 0; n_hi = 0;
        pulse_start();
        wait_idle();
        probes = n_lo - 1;
        check(probes >= 2, "R9 retried while converting", probes, 2);
        check(lo_dur[0] == HALF, "R9 probe select-low length", lo_dur[0], HALF);
        check(hi_dur[1] == GAP, "R9 back-off length", hi_dur[1], GAP);
        check(lo_dur[probes - 1] == HALF, "R10 ready probe length", lo_dur[probes - 1], HALF);
        check(hi_dur[probes] == HALF, "R10 gap before read", hi_dur[probes], HALF);
        check(got_word == exp, "R10 word after polling", got_word, exp);
        poll_en = 1'b0;
        settle();
    endtask

    // ---------------- watchdog and sequence ----------------
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_sel_hi();
        t_clk_hi();
        t_clk_lo();
        t_sel_lo();
        t_immediate_and_busy();
        t_latch();
        t_poll();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule